// File: doc/BRIEF.md
# Up-Counting Timer with Software Compare Channel

This peripheral holds one counter that climbs from zero to a programmable terminal value, drops back to zero and raises an overflow flag. The counter advances on prescaled clock ticks, where the tick rate is the input clock divided by two raised to a 3-bit exponent. A single compare channel watches the count. When the channel is armed with the software-compare mode code and the count steps onto the channel's value, the channel raises a flag, and that flag can drive an interrupt line.

Software reaches the block through a flat register bus. Each write is a single-cycle strobe with an address and a 32-bit data word, and reads are combinational from the address. Software reads the live count whenever it needs to. It clears flags by writing ones to them. A read-only register tells software how wide the counter was built.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter, status-and-control (0x10), channel control (0x20), channel value (0x24) and status (0x1C) read zero, the modulo register (0x18) reads all ones for the counter width, and `irq` is low.
- R2: The register at 0x04 returns the counter width in bits 23:16 and zero elsewhere.
- R3: The counter advances only while bits 4:3 of 0x10 hold 2'b01. Any other value holds the count.
- R4: With bits 2:0 of 0x10 holding p, the counter advances once every 2^p clocks while running.
- R5: A tick taken at a count equal to the modulo register loads zero and sets bit 7 of 0x10. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R6: Any write to 0x14 sets the count to zero.
- R7: The channel flag (bit 7 of 0x20) is set when bits 5:2 of 0x20 hold 4 and the counter advances to the value in 0x24. With any other mode code the flag stays clear.
- R8: Status bit 0 (0x1C) mirrors the channel flag. The flag is cleared by writing 1 to either status bit 0 or bit 7 of 0x20, and writing 0 to status bit 0 has no effect.
- R9: `irq` is high exactly while the channel flag is set and bit 6 of 0x20 is 1.
- R10: A match is detected only when the count steps onto the value. Loading a value the count has already passed raises no flag until the counter wraps and reaches it again.
- R11: The count, modulo and channel value registers keep only the counter width, and reads return zero above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Compare interrupt, level |

## Verification
The bench builds the block with a 16-bit counter. At that width a run of 65,538 ticks carries the counter all the way through the all-ones terminal count and back to zero, so the free-running wrap can be observed. It also makes the width report and the truncation of the upper register bits visible. The prescaler keeps its 3-bit exponent, so the bench can test both divide-by-4 and divide-by-128 with short runs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int PSC_W = 3;

    localparam logic [7:0] OFS_INFO  = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h14;
    localparam logic [7:0] OFS_WRAP  = 8'h18;
    localparam logic [7:0] OFS_STAT  = 8'h1C;
    localparam logic [7:0] OFS_CHCTL = 8'h20;
    localparam logic [7:0] OFS_CHVAL = 8'h24;

    localparam logic [1:0] CMODE_RUN = 2'b01;
    localparam logic [3:0] CHMODE_SWCMP = 4'h4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        pre_d = pre_q;
        mask  = (DIV_W'(1) << psc) - DIV_W'(1);
        tick  = run && ((pre_q.div & mask) == mask);
        pre_d.div = run ? pre_q.div + DIV_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc != '0) |=> (!tick || psc == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] wrap,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_arm,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt,
    output logic             hit_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        cnt_d    = cnt_q;
        nxt      = (cnt_q.cnt == wrap) ? '0 : cnt_q.cnt + CNT_W'(1);
        wrap_evt = tick && !clr && (cnt_q.cnt == wrap);
        hit_evt  = tick && !clr && cmp_arm && (nxt == cmp_val);
        if (clr)       cnt_d.cnt = '0;
        else if (tick) cnt_d.cnt = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q.cnt));
    // R6
    clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q.cnt == '0));
    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (cnt_q.cnt == '0));
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [1:0]       cmode;
        logic             ovf;
        logic [3:0]       chmode;
        logic             chie;
        logic             chf;
        logic [CNT_W-1:0] wrap;
        logic [CNT_W-1:0] chval;
    } regs_t;

    regs_t r_d, r_q;
    logic [CNT_W-1:0] count;
    logic wrap_evt, hit_evt, tick, run, arm, cnt_clr;
    logic wr_ctrl, wr_wrap, wr_stat, wr_chctl, wr_chval;

    assign run = (r_q.cmode == CMODE_RUN);
    assign arm = (r_q.chmode == CHMODE_SWCMP);

    tmr_prescaler #(.PSC_W(PSC_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .psc(r_q.psc), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr),
        .wrap(r_q.wrap), .cmp_val(r_q.chval), .cmp_arm(arm),
        .count(count), .wrap_evt(wrap_evt), .hit_evt(hit_evt)
    );

    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_wrap  = bus_we && (bus_addr == ADDR_W'(OFS_WRAP));
        wr_stat  = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
        wr_chctl = bus_we && (bus_addr == ADDR_W'(OFS_CHCTL));
        wr_chval = bus_we && (bus_addr == ADDR_W'(OFS_CHVAL));
        cnt_clr  = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.psc   = bus_wdata[PSC_W-1:0];
            r_d.cmode = bus_wdata[4:3];
            if (bus_wdata[7]) r_d.ovf = 1'b0;
        end
        if (wrap_evt) r_d.ovf = 1'b1;
        if (wr_wrap)  r_d.wrap  = bus_wdata[CNT_W-1:0];
        if (wr_chval) r_d.chval = bus_wdata[CNT_W-1:0];
        if (wr_chctl) begin
            r_d.chmode = bus_wdata[5:2];
            r_d.chie   = bus_wdata[6];
            if (bus_wdata[7]) r_d.chf = 1'b0;
        end
        if (wr_stat && bus_wdata[0]) r_d.chf = 1'b0;
        if (hit_evt) r_d.chf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.wrap <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_INFO):  bus_rdata[23:16] = 8'(CNT_W);
            ADDR_W'(OFS_CTRL):  bus_rdata = {24'b0, r_q.ovf, 2'b0, r_q.cmode, r_q.psc};
            ADDR_W'(OFS_COUNT): bus_rdata = 32'(count);
            ADDR_W'(OFS_WRAP):  bus_rdata = 32'(r_q.wrap);
            ADDR_W'(OFS_STAT):  bus_rdata = {31'b0, r_q.chf};
            ADDR_W'(OFS_CHCTL): bus_rdata = {24'b0, r_q.chf, r_q.chie, r_q.chmode, 2'b0};
            ADDR_W'(OFS_CHVAL): bus_rdata = 32'(r_q.chval);
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = r_q.chf & r_q.chie;

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> r_q.ovf);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_evt |=> r_q.chf);
    // R10
    flag_on_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.chf) |-> (count == $past(r_q.chval)));
    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[0] && !hit_evt) |=> !r_q.chf);
    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit_evt) || $rose(r_q.chie)));
endmodule

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
    localparam int CNT_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    event  smp;

    localparam logic [7:0] A_INFO = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14,
        A_WRAP = 8'h18, A_STAT = 8'h1C, A_CHC = 8'h20, A_CHV = 8'h24, A_IRQ = 8'hFF;

    tmr_top #(.CNT_W(CNT_W), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(smp);
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                act = (it.addr == A_IRQ) ? {31'b0, irq} : bus_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        if (a != A_IRQ) bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        #1;
        ->smp;
        @(negedge clk);
    endtask

    // run with the given control word for n clock edges, then stop
    task automatic run_for(input logic [31:0] ctl, input int n);
        wr(A_CTRL, ctl);
        repeat (n - 1) @(negedge clk);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(A_CTRL, 32'h0, "R1 ctrl");
        chk(A_CNT, 32'h0, "R1 count");
        chk(A_WRAP, 32'h0000FFFF, "R1 wrap");
        chk(A_CHC, 32'h0, "R1 chctl");
        chk(A_CHV, 32'h0, "R1 chval");
        chk(A_STAT, 32'h0, "R1 stat");
        chk(A_IRQ, 32'h0, "R1 irq");
        // R2 width report
        chk(A_INFO, 32'h00100000, "R2 info");

        // R3 run and hold
        run_for(32'h08, 10);
        chk(A_CNT, 32'd10, "R3 run");
        repeat (5) @(negedge clk);
        chk(A_CNT, 32'd10, "R3 hold");
        run_for(32'h18, 6);
        chk(A_CNT, 32'd10, "R3 mode11");

        // R6 count write clears
        wr(A_CNT, 32'h1234);
        chk(A_CNT, 32'd0, "R6 clear");

        // R4 prescaler
        run_for(32'h0A, 21);
        chk(A_CNT, 32'd5, "R4 div4");
        wr(A_CNT, 0);
        run_for(32'h0F, 300);
        chk(A_CNT, 32'd2, "R4 div128");

        // R5 modulo wrap and overflow flag
        wr(A_CNT, 0);
        wr(A_WRAP, 32'd5);
        run_for(32'h08, 14);
        chk(A_CNT, 32'd2, "R5 wrap count");
        chk(A_CTRL, 32'h80, "R5 ovf set");
        wr(A_CTRL, 32'h00);
        chk(A_CTRL, 32'h80, "R5 write0 keeps");
        wr(A_CTRL, 32'h80);
        chk(A_CTRL, 32'h00, "R5 w1c");
        wr(A_WRAP, 32'hFFFF);
        wr(A_CNT, 0);

        // R11 truncation
        wr(A_CHV, 32'hABCD0007);
        chk(A_CHV, 32'h00000007, "R11 chval");
        wr(A_WRAP, 32'h1234FFFF);
        chk(A_WRAP, 32'h0000FFFF, "R11 wrap");

        // R7 R8 R9 compare hit with interrupt enabled
        wr(A_CHC, 32'h50);
        run_for(32'h08, 10);
        chk(A_CNT, 32'd10, "R7 count");
        chk(A_CHC, 32'hD0, "R7 flag");
        chk(A_STAT, 32'h1, "R8 mirror");
        chk(A_IRQ, 32'h1, "R9 irq high");
        wr(A_STAT, 32'h0);
        chk(A_STAT, 32'h1, "R8 write0");
        wr(A_STAT, 32'h1);
        chk(A_STAT, 32'h0, "R8 stat w1c");
        chk(A_CHC, 32'h50, "R8 chctl after clear");
        chk(A_IRQ, 32'h0, "R9 irq low");

        // R10 value already passed
        wr(A_CHV, 32'd5);
        run_for(32'h08, 10);
        chk(A_CNT, 32'd20, "R10 count");
        chk(A_STAT, 32'h0, "R10 no flag");
        wr(A_WRAP, 32'd20);
        run_for(32'h08, 6);
        chk(A_CNT, 32'd5, "R10 after wrap");
        chk(A_STAT, 32'h1, "R10 flag after wrap");
        wr(A_CTRL, 32'h80);
        // R8 clear through channel control
        wr(A_CHC, 32'hD0);
        chk(A_CHC, 32'h50, "R8 chctl w1c");
        chk(A_STAT, 32'h0, "R8 stat after chctl");
        wr(A_WRAP, 32'hFFFF);

        // R9 interrupt disabled
        wr(A_CHC, 32'h10);
        wr(A_CNT, 0);
        run_for(32'h08, 6);
        chk(A_STAT, 32'h1, "R9 flag no ie");
        chk(A_IRQ, 32'h0, "R9 masked");
        wr(A_STAT, 32'h1);

        // R7 other mode code
        wr(A_CHC, 32'h44);
        wr(A_CNT, 0);
        run_for(32'h08, 8);
        chk(A_STAT, 32'h0, "R7 not armed");
        chk(A_IRQ, 32'h0, "R7 no irq");

        // R5 free-running full range
        wr(A_CHC, 32'h0);
        wr(A_CNT, 0);
        run_for(32'h08, 65538);
        chk(A_CNT, 32'd2, "R5 full wrap count");
        chk(A_CTRL, 32'h80, "R5 full wrap ovf");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule